// File: doc/BRIEF.md
# NOR Flash Erase Timing Controller

This block models the timing side of erase operations in an emulated parallel NOR flash, and it produces the status byte that a host polls while an operation is running. A separate command decoder sends it single-cycle pulses: sector erase (with a sector index), chip erase, suspend, resume, and a catch-all "other command" pulse. A 1 µs tick enable drives every time interval. Command decoding, the storage array and sector-size lookup are handled elsewhere. This block only tells the read path whether an access should return the status byte or array data.

A sector erase opens a short acceptance window. Further sector erases can join the batch while the window is open. When the window closes, an erase timer starts, and its length is proportional to the number of sectors in the batch. A chip erase runs for a single fixed time. An erase that is suspended keeps its remaining time and resumes later from that point. Status reads toggle DQ6 and DQ2 in patterns that show which kind of operation is active.

Top module: `nor_erase_timer`

## Requirements
- R1: After reset, `status_byte` is 0, `erase_map` is 0, and `busy`, `suspended` and `done` are all low. Status byte layout: bit 7 = DQ7, bit 6 = DQ6, bit 3 = DQ3, bit 2 = DQ2. All other bits are 0.
- R2: A sector erase accepted while idle and not suspended does four things: it sets bit `sector_idx` of `erase_map`, clears DQ7 and DQ3, raises `busy`, and loads a window of WINDOW_US ticks.
- R3: While the window is open, a sector erase reloads the window. It adds the sector to the batch only if that sector is not already marked. A chip erase, a resume or an other-command pulse aborts: the map is cleared, `busy` falls, and no `done` pulse is produced. A tick in the same cycle as any command is not counted.
- R4: At the last window tick, DQ3 is set and the erase timer is loaded with (marked sectors) × 2^BLK_EXP × US_PER_MS ticks.
- R5: At the last erase tick, the map is cleared, DQ3 is cleared, DQ7 is inverted, `busy` falls, and `done` pulses for one cycle.
- R6: A chip erase clears DQ7 and runs for 2^CHIP_EXP × US_PER_MS ticks. Every command is ignored during that time. When it ends, DQ7 inverts and `done` pulses.
- R7: A status read (`status_rd`) while `busy` toggles both DQ6 and DQ2 on the next edge. While idle with `prog_active` high, only DQ6 toggles.
- R8: A suspend during the window saves the full batch time. A suspend during the erase saves the remaining ticks, with a minimum of 1. In both cases DQ3 is cleared, the timer stops, `busy` falls, `suspended` rises and the map is kept.
- R9: While suspended, a read of a marked sector asserts `rd_status` and toggles only DQ2. A read of an unmarked sector (with `prog_active` low) leaves `rd_status` low and toggles nothing.
- R10: A resume while suspended reloads the timer with the saved time, clears `suspended`, sets DQ3, clears DQ7 and raises `busy`.
- R11: While suspended, sector erase and chip erase commands are refused: `busy` stays low and the map is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | 1 µs timing enable |
| cmd_sector_erase | input | 1 | Sector erase command pulse |
| cmd_chip_erase | input | 1 | Chip erase command pulse |
| cmd_suspend | input | 1 | Erase suspend pulse |
| cmd_resume | input | 1 | Erase resume pulse |
| cmd_other | input | 1 | Any other decoded command |
| sector_idx | input | $clog2(NUM_SECTORS) | Sector for a sector erase |
| status_rd | input | 1 | Host read strobe |
| rd_sector | input | $clog2(NUM_SECTORS) | Sector addressed by the read |
| prog_active | input | 1 | A program operation is in progress |
| status_byte | output | 8 | DQ7/DQ6/DQ3/DQ2 status |
| rd_status | output | 1 | Current read should return the status byte |
| busy | output | 1 | Window, sector erase or chip erase in progress |
| suspended | output | 1 | A suspended erase is held |
| erase_map | output | NUM_SECTORS | Sectors in the current or suspended batch |
| done | output | 1 | One-cycle pulse when an erase completes |

## Verification
Any fault in the timer or pending-count state shows up as a `done` pulse and a DQ7 inversion that arrive on the wrong clock. A reference model compared on every cycle catches this at the exact edge, even when the error is only one tick. A wrong suspend value appears only after the resume, as a late or early completion. For this reason the scenarios suspend both inside the window and partway through an erase, then run each batch to its end. Toggle errors on DQ6 or DQ2 show up on the status byte one cycle after the offending read.

// File: rtl/nor_erase_timer.sv
module nor_erase_timer #(
  parameter int NUM_SECTORS = 8,
  parameter int US_PER_MS   = 1000,
  parameter int WINDOW_US   = 50,
  parameter int BLK_EXP     = 9,
  parameter int CHIP_EXP    = 12,
  parameter int TIME_W      = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tick_us,
  input  logic                           cmd_sector_erase,
  input  logic                           cmd_chip_erase,
  input  logic                           cmd_suspend,
  input  logic                           cmd_resume,
  input  logic                           cmd_other,
  input  logic [$clog2(NUM_SECTORS)-1:0] sector_idx,
  input  logic                           status_rd,
  input  logic [$clog2(NUM_SECTORS)-1:0] rd_sector,
  input  logic                           prog_active,
  output logic [7:0]                     status_byte,
  output logic                           rd_status,
  output logic                           busy,
  output logic                           suspended,
  output logic [NUM_SECTORS-1:0]         erase_map,
  output logic                           done
);
  localparam int CNT_W = $clog2(NUM_SECTORS + 1);
  localparam logic [TIME_W-1:0] WIN_T  = TIME_W'(WINDOW_US);
  localparam logic [TIME_W-1:0] BLK_T  = TIME_W'(US_PER_MS) << BLK_EXP;
  localparam logic [TIME_W-1:0] CHIP_T = TIME_W'(US_PER_MS) << CHIP_EXP;
  localparam logic [TIME_W-1:0] ONE_T  = TIME_W'(1);

  typedef enum logic [1:0] {M_IDLE, M_WIN, M_SEC, M_CHIP} mode_t;

  mode_t             mode;
  logic [TIME_W-1:0] tmr, saved;
  logic [CNT_W-1:0]  npend;
  logic              dq7, dq6, dq3, dq2;

  wire [TIME_W-1:0] batch_t = TIME_W'(npend) * BLK_T;
  wire              last    = tick_us && (tmr == ONE_T);
  wire              marked  = erase_map[rd_sector];
  wire              susp_hit = suspended && marked;
  wire              tog2 = status_rd && (busy || susp_hit);
  wire              tog6 = status_rd && (busy || (!susp_hit && prog_active));

  assign busy        = (mode != M_IDLE);
  assign suspended   = (saved != '0);
  assign rd_status   = busy || susp_hit || prog_active;
  assign status_byte = {dq7, dq6, 2'b00, dq3, dq2, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_IDLE; tmr <= '0; saved <= '0; npend <= '0; erase_map <= '0;
      dq7 <= 1'b0; dq6 <= 1'b0; dq3 <= 1'b0; dq2 <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tog2) dq2 <= ~dq2;
      if (tog6) dq6 <= ~dq6;
      case (mode)
        M_IDLE: begin
          if (!suspended) begin
            if (cmd_sector_erase) begin
              erase_map <= NUM_SECTORS'(1) << sector_idx;
              npend <= CNT_W'(1);
              dq7 <= 1'b0; dq3 <= 1'b0;
              tmr <= WIN_T; mode <= M_WIN;
            end else if (cmd_chip_erase) begin
              dq7 <= 1'b0;
              tmr <= CHIP_T; mode <= M_CHIP;
            end
          end else if (cmd_resume) begin
            tmr <= saved; saved <= '0;
            dq3 <= 1'b1; dq7 <= 1'b0;
            mode <= M_SEC;
          end
        end
        M_WIN: begin
          if (cmd_sector_erase) begin
            if (!erase_map[sector_idx]) npend <= npend + CNT_W'(1);
            erase_map <= erase_map | (NUM_SECTORS'(1) << sector_idx);
            dq7 <= 1'b0;
            tmr <= WIN_T;
          end else if (cmd_suspend) begin
            saved <= batch_t; tmr <= '0; mode <= M_IDLE;
          end else if (cmd_other || cmd_chip_erase || cmd_resume) begin
            erase_map <= '0; npend <= '0; tmr <= '0; mode <= M_IDLE;
          end else if (last) begin
            dq3 <= 1'b1; tmr <= batch_t; mode <= M_SEC;
          end else if (tick_us) begin
            tmr <= tmr - ONE_T;
          end
        end
        M_SEC: begin
          if (cmd_suspend) begin
            saved <= (tmr == '0) ? ONE_T : tmr;
            tmr <= '0; dq3 <= 1'b0; mode <= M_IDLE;
          end else if (last) begin
            erase_map <= '0; npend <= '0; tmr <= '0;
            dq3 <= 1'b0; dq7 <= ~dq7; done <= 1'b1; mode <= M_IDLE;
          end else if (tick_us) begin
            tmr <= tmr - ONE_T;
          end
        end
        M_CHIP: begin
          if (last) begin
            tmr <= '0; dq7 <= ~dq7; done <= 1'b1; mode <= M_IDLE;
          end else if (tick_us) begin
            tmr <= tmr - ONE_T;
          end
        end
        default: mode <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_erase_timer_chk.sv
module nor_erase_timer_chk #(
  parameter int NUM_SECTORS = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           cmd_sector_erase,
  input logic                           cmd_chip_erase,
  input logic                           cmd_resume,
  input logic [$clog2(NUM_SECTORS)-1:0] sector_idx,
  input logic [7:0]                     status_byte,
  input logic                           busy,
  input logic                           suspended,
  input logic [NUM_SECTORS-1:0]         erase_map,
  input logic                           done
);
  a_r2_mark_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !suspended && cmd_sector_erase)
      |=> (erase_map[$past(sector_idx)] && !status_byte[7] && busy));

  a_r4_dq3_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[3] |-> busy);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && erase_map == '0 && !status_byte[3] && status_byte[7]));

  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r8_suspend_dq3_low: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (!status_byte[3] && !busy));

  a_r11_refuse_new: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !busy && !cmd_resume && (cmd_sector_erase || cmd_chip_erase))
      |=> (!busy && erase_map == $past(erase_map)));
endmodule

bind nor_erase_timer nor_erase_timer_chk #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_sector_erase(cmd_sector_erase),
  .cmd_chip_erase(cmd_chip_erase), .cmd_resume(cmd_resume),
  .sector_idx(sector_idx), .status_byte(status_byte), .busy(busy),
  .suspended(suspended), .erase_map(erase_map), .done(done)
);

// File: tb/nor_erase_timer_tb.sv
module nor_erase_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 8;
  localparam int UPM = 4;
  localparam int WIN = 5;
  localparam int BE  = 2;
  localparam int CE  = 3;
  localparam int BLK  = UPM * (1 << BE);
  localparam int CHIP = UPM * (1 << CE);
  localparam int SW = $clog2(NS);

  logic clk = 0, rst_n = 0, tick_us = 0;
  logic cmd_sector_erase = 0, cmd_chip_erase = 0, cmd_suspend = 0, cmd_resume = 0, cmd_other = 0;
  logic [SW-1:0] sector_idx = '0, rd_sector = '0;
  logic status_rd = 0, prog_active = 0;
  logic [7:0] status_byte;
  logic rd_status, busy, suspended, done;
  logic [NS-1:0] erase_map;

  nor_erase_timer #(.NUM_SECTORS(NS), .US_PER_MS(UPM), .WINDOW_US(WIN),
                    .BLK_EXP(BE), .CHIP_EXP(CE), .TIME_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .cmd_sector_erase(cmd_sector_erase), .cmd_chip_erase(cmd_chip_erase),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cmd_other(cmd_other),
    .sector_idx(sector_idx), .status_rd(status_rd), .rd_sector(rd_sector),
    .prog_active(prog_active), .status_byte(status_byte), .rd_status(rd_status),
    .busy(busy), .suspended(suspended), .erase_map(erase_map), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit tick_on = 1;

  // reference model
  int m_mode = 0, m_rem = 0, m_saved = 0;
  int pend[$];
  bit e7 = 0, e6 = 0, e3 = 0, e2 = 0, e_done = 0;
  bit was_busy, susp, mk;

  function automatic bit in_batch(int s);
    foreach (pend[i]) if (pend[i] == s) return 1;
    return 0;
  endfunction

  function automatic logic [NS-1:0] exp_map();
    logic [NS-1:0] v = '0;
    foreach (pend[i]) v[pend[i]] = 1'b1;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_rem = 0; m_saved = 0; pend.delete();
      e7 = 0; e6 = 0; e3 = 0; e2 = 0; e_done = 0;
    end else begin
      was_busy = (m_mode != 0);
      susp = (m_saved != 0);
      mk = in_batch(int'(rd_sector));
      e_done = 0;
      if (status_rd) begin
        if (was_busy) begin e2 = !e2; e6 = !e6; end
        else if (susp && mk) e2 = !e2;
        else if (prog_active) e6 = !e6;
      end
      case (m_mode)
        0: begin
          if (!susp) begin
            if (cmd_sector_erase) begin
              pend.delete(); pend.push_back(int'(sector_idx));
              e7 = 0; e3 = 0; m_rem = WIN; m_mode = 1;
            end else if (cmd_chip_erase) begin
              e7 = 0; m_rem = CHIP; m_mode = 3;
            end
          end else if (cmd_resume) begin
            m_rem = m_saved; m_saved = 0; e3 = 1; e7 = 0; m_mode = 2;
          end
        end
        1: begin
          if (cmd_sector_erase) begin
            if (!in_batch(int'(sector_idx))) pend.push_back(int'(sector_idx));
            e7 = 0; m_rem = WIN;
          end else if (cmd_suspend) begin
            m_saved = pend.size() * BLK; m_rem = 0; m_mode = 0;
          end else if (cmd_other || cmd_chip_erase || cmd_resume) begin
            pend.delete(); m_rem = 0; m_mode = 0;
          end else if (tick_us) begin
            m_rem--;
            if (m_rem == 0) begin e3 = 1; m_rem = pend.size() * BLK; m_mode = 2; end
          end
        end
        2: begin
          if (cmd_suspend) begin
            m_saved = (m_rem < 1) ? 1 : m_rem; m_rem = 0; e3 = 0; m_mode = 0;
          end else if (tick_us) begin
            m_rem--;
            if (m_rem == 0) begin pend.delete(); e3 = 0; e7 = !e7; e_done = 1; m_mode = 0; end
          end
        end
        default: begin
          if (tick_us) begin
            m_rem--;
            if (m_rem == 0) begin e7 = !e7; e_done = 1; m_mode = 0; end
          end
        end
      endcase
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from both edges
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        chk(cur_req, "status_byte", status_byte, {e7, e6, 2'b00, e3, e2, 2'b00});
        chk(cur_req, "busy", busy, m_mode != 0);
        chk(cur_req, "suspended", suspended, m_saved != 0);
        chk(cur_req, "erase_map", erase_map, exp_map());
        chk(cur_req, "done", done, e_done);
        chk(cur_req, "rd_status", rd_status,
            (m_mode != 0) || (m_saved != 0 && in_batch(int'(rd_sector))) || prog_active);
      end
    end
  end

  // tick generator: one tick every third cycle
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      tick_us = tick_on && (div == 2);
      div = (div + 1) % 3;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sec(int s);
    @(negedge clk); cmd_sector_erase = 1; sector_idx = SW'(s);
    @(negedge clk); cmd_sector_erase = 0;
  endtask
  task automatic chip();
    @(negedge clk); cmd_chip_erase = 1; @(negedge clk); cmd_chip_erase = 0;
  endtask
  task automatic susp_cmd();
    @(negedge clk); cmd_suspend = 1; @(negedge clk); cmd_suspend = 0;
  endtask
  task automatic resume();
    @(negedge clk); cmd_resume = 1; @(negedge clk); cmd_resume = 0;
  endtask
  task automatic other();
    @(negedge clk); cmd_other = 1; @(negedge clk); cmd_other = 0;
  endtask
  task automatic rd(int s);
    @(negedge clk); status_rd = 1; rd_sector = SW'(s);
    @(negedge clk); status_rd = 0;
  endtask

  task automatic wait_idle(int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; #2;
    cur_req = "R1";
    chk("R1", "status after reset", status_byte, 0);
    chk("R1", "map after reset", erase_map, 0);
    cyc(4);

    cur_req = "R2";
    sec(3); #2;
    chk("R2", "busy after accept", busy, 1);
    chk("R2", "map bit 3", erase_map[3], 1);
    cur_req = "R4";
    cyc(10);
    cur_req = "R5";
    wait_idle(500);
    cyc(1); #2;
    chk("R5", "dq7 set after completion", status_byte[7], 1);
    chk("R5", "map cleared", erase_map, 0);

    cur_req = "R3";
    sec(1); cyc(4); sec(5); cyc(2); sec(5); cyc(3);
    cur_req = "R4";
    wait_idle(800);
    cyc(3);
    cur_req = "R3";
    sec(2); cyc(2); other(); #2;
    chk("R3", "abort leaves idle", busy, 0);
    chk("R3", "abort clears map", erase_map, 0);
    sec(6); cyc(1); chip(); cyc(2);
    sec(7); cyc(1); resume(); cyc(4);

    cur_req = "R7";
    prog_active = 1; rd(0); rd(1); cyc(1);
    prog_active = 0; cyc(1);
    sec(0); rd(0); rd(4); cyc(20); rd(0); rd(2);
    wait_idle(500); cyc(2);

    cur_req = "R8";
    sec(4); cyc(3); sec(6); cyc(2); susp_cmd(); cyc(2); #2;
    chk("R8", "suspended in window", suspended, 1);
    chk("R8", "map kept", erase_map, 8'h50);
    cur_req = "R9";
    rd(4); rd(6); rd(1); cyc(2);
    @(negedge clk); status_rd = 1; rd_sector = 3'd4; #2;
    chk("R9", "rd_status marked", rd_status, 1);
    @(negedge clk); rd_sector = 3'd2; #2;
    chk("R9", "rd_status unmarked", rd_status, 0);
    @(negedge clk); status_rd = 0;
    cur_req = "R11";
    sec(1); chip(); cyc(3); #2;
    chk("R11", "refused erase", busy, 0);
    chk("R11", "map unchanged", erase_map, 8'h50);
    cur_req = "R10";
    resume(); #2;
    chk("R10", "busy after resume", busy, 1);
    chk("R10", "dq3 after resume", status_byte[3], 1);
    cyc(40);
    cur_req = "R8";
    susp_cmd(); cyc(5); rd(6);
    cur_req = "R10";
    resume(); cyc(5);
    cur_req = "R5";
    wait_idle(800); cyc(3);

    cur_req = "R6";
    chip(); cyc(3); sec(2); susp_cmd(); other(); resume(); rd(3); cyc(5); #2;
    chk("R6", "chip erase still busy", busy, 1);
    wait_idle(500); cyc(1); #2;
    chk("R6", "dq7 after chip erase", status_byte[7], 1);
    cyc(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule